// File: doc/BRIEF.md
# Capture Buffer with Fill-Threshold DMA Request

This block sits between a pixel capture front end and a system bus reader. It stores 32-bit captured words in a 128-entry first-in first-out buffer. The capture logic pushes words with a write strobe, and the bus side pops them with a read strobe. Read data is registered.

A programmable fill threshold drives a DMA request line. A 7-bit code n selects a threshold of n+1 words, so every depth from 1 to 128 can be selected. The request stays low while the DMA enable input is low.

Five event flags latch buffer conditions: not empty, full, threshold reached, overflow and underflow. The bus clears each flag by writing 1 to it. Each flag has its own mask, and the interrupt line is the OR of the unmasked flags. For diagnosis, the block also exposes both pointers, the current fill level and the highest level reached since reset.

Top module: `cap_fifo_dma`

## Requirements
- R1: After reset, fill level, peak, both pointers, read data and all status flags are 0, and the DMA request and the interrupt line are low.
- R2: Words leave in the order they were written. An accepted read (read strobe with level above 0) presents its word on the read data output after the same clock edge.
- R3: The fill level rises by 1 for each accepted write and falls by 1 for each accepted read, and stays unchanged when both occur on the same edge. Its range is 0 to 128. Each pointer advances by one per accepted access and wraps from 127 to 0.
- R4: A write strobe at level 128 is dropped: the level and write pointer do not change, and status bit 3 (overflow) is set.
- R5: A read strobe at level 0 leaves read data, read pointer and level unchanged, and sets status bit 4 (underflow).
- R6: With DMA enable high, the DMA request is high exactly when the current level is at least threshold code + 1. The request follows the level without delay, so it drops in the cycle the level falls below the threshold.
- R7: With DMA enable low, the DMA request is low for every level and threshold code.
- R8: The peak output equals the highest level held since reset. Reads and flag clears do not lower it.
- R9: Status bits 0 (level above 0), 1 (level equals 128) and 2 (level at least threshold code + 1) are set on the clock edge after the level that meets their condition is present.
- R10: On the clear input, writing 1 to a status bit clears it and writing 0 leaves it unchanged. If the bit's event is present on the same edge, the set takes priority over the clear.
- R11: The interrupt line is high exactly when some status bit and its enable bit, at the same position, are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push strobe from capture logic |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop strobe from bus reader |
| rd_data | output | 32 | Registered popped word |
| thr_code | input | 7 | Threshold code n, threshold = n+1 words |
| dma_en | input | 1 | Enables the DMA request line |
| irq_en | input | 5 | Per-flag interrupt enables (bit order as status) |
| stat_clr | input | 5 | Write-1-to-clear strobes for status flags |
| stat | output | 5 | Status flags: 0 not empty, 1 full, 2 threshold, 3 overflow, 4 underflow |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt line |
| wr_ptr | output | 7 | Write pointer |
| rd_ptr | output | 7 | Read pointer |
| level | output | 8 | Current fill level, 0 to 128 |
| peak | output | 8 | Highest fill level since reset |

## Verification
The assertions assume that reset is applied at the start, that every strobe and code input is at a known value on each clock edge, and that the clear input only carries meaningful bits during the cycles in which it is driven. The stimulus changes inputs one time unit after a rising edge and returns the strobes and clears to 0 after each cycle. The threshold sweep changes the code only between edges, and sets it back to a fixed value before the next edge. This way the threshold flag and the peak are only ever computed from stable inputs.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
   localparam int unsigned NUM_EV = 5;
   typedef enum int unsigned {
      EV_NONEMPTY = 0,
      EV_FULL     = 1,
      EV_THRESH   = 2,
      EV_OVFL     = 3,
      EV_UNFL     = 4
   } ev_idx_e;
endpackage

// File: rtl/cfd_mem.sv
module cfd_mem #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned PTR_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_go,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_go) store[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_go) rd_data <= store[rd_ptr];
   end

   // R5: a read that is not accepted keeps the output word
   p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(rd_data));
endmodule

// File: rtl/cfd_ctrl.sv
module cfd_ctrl #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned PTR_W = 7,
   parameter int unsigned LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic             wr_go,
   output logic             rd_go,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] peak
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic [LVL_W-1:0] lvl_nxt;

   assign wr_go = wr_req && (level != FULL_LVL);
   assign rd_go = rd_req && (level != '0);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_comb begin
      lvl_nxt = level;
      case ({wr_go, rd_go})
         2'b10:   lvl_nxt = level + 1'b1;
         2'b01:   lvl_nxt = level - 1'b1;
         default: lvl_nxt = level;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         peak   <= '0;
      end else begin
         if (wr_go) wr_ptr <= wr_nxt;
         if (rd_go) rd_ptr <= rd_nxt;
         level <= lvl_nxt;
         if (lvl_nxt > peak) peak <= lvl_nxt;
      end
   end

   // R3: level never exceeds depth
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);
   // R4: write at full leaves the write pointer
   p_ovfl_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && level == FULL_LVL) |=> $stable(wr_ptr));
   // R8: peak never below current level
   p_peak_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      peak >= level);
   // R8: peak never decreases
   p_peak_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> peak >= $past(peak));
endmodule

// File: rtl/cfd_irq.sv
module cfd_irq #(
   parameter int unsigned NUM_EV = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev,
   input  logic [NUM_EV-1:0] clr,
   input  logic [NUM_EV-1:0] en,
   output logic [NUM_EV-1:0] stat,
   output logic              irq
);
   logic [NUM_EV-1:0] masked;

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stat[i] <= 1'b0;
            else if (ev[i])  stat[i] <= 1'b1;
            else if (clr[i]) stat[i] <= 1'b0;
         end
         assign masked[i] = stat[i] & en[i];

         // R9: an event is latched on the next edge
         p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> stat[i]);
         // R10: a clear with no event empties the flag
         p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ev[i]) |=> !stat[i]);
         // R10: without clear the flag does not drop
         p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr[i]) |=> stat[i]);
      end
   endgenerate

   assign irq = |masked;
endmodule

// File: rtl/cap_fifo_dma.sv
module cap_fifo_dma #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned PTR_W  = $clog2(DEPTH),
   parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       rd_en,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [PTR_W-1:0]           thr_code,
   input  logic                       dma_en,
   input  logic [cfd_pkg::NUM_EV-1:0] irq_en,
   input  logic [cfd_pkg::NUM_EV-1:0] stat_clr,
   output logic [cfd_pkg::NUM_EV-1:0] stat,
   output logic                       dma_req,
   output logic                       irq,
   output logic [PTR_W-1:0]           wr_ptr,
   output logic [PTR_W-1:0]           rd_ptr,
   output logic [LVL_W-1:0]           level,
   output logic [LVL_W-1:0]           peak
);
   import cfd_pkg::*;

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cap_fifo_dma: DEPTH must be at least 2");
      end
      if (PTR_W != $clog2(DEPTH)) begin : g_bad_ptr
         $error("cap_fifo_dma: PTR_W must equal clog2(DEPTH)");
      end
      if (LVL_W != $clog2(DEPTH + 1)) begin : g_bad_lvl
         $error("cap_fifo_dma: LVL_W must equal clog2(DEPTH+1)");
      end
      if (DATA_W == 0) begin : g_bad_data
         $error("cap_fifo_dma: DATA_W must be nonzero");
      end
   endgenerate

   logic             wr_go, rd_go;
   logic [LVL_W-1:0] thr_lvl;
   logic             at_thr;
   logic [NUM_EV-1:0] ev;

   cfd_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
      .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .level(level), .peak(peak));

   cfd_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) mem_i (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_ptr(wr_ptr),
      .wr_data(wr_data), .rd_go(rd_go), .rd_ptr(rd_ptr), .rd_data(rd_data));

   assign thr_lvl = LVL_W'(thr_code) + 1'b1;
   assign at_thr  = (level >= thr_lvl);
   assign dma_req = dma_en && at_thr;

   always_comb begin
      ev              = '0;
      ev[EV_NONEMPTY] = (level != '0);
      ev[EV_FULL]     = (level == FULL_LVL);
      ev[EV_THRESH]   = at_thr;
      ev[EV_OVFL]     = wr_en && (level == FULL_LVL);
      ev[EV_UNFL]     = rd_en && (level == '0);
   end

   cfd_irq #(.NUM_EV(NUM_EV)) irq_i (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(stat_clr), .en(irq_en),
      .stat(stat), .irq(irq));

   // R7: disabled DMA never requests
   p_dma_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !dma_req);
   // R5: underflow read changes neither data nor level
   p_unfl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && level == '0) |=> ($stable(rd_data) && level == '0));
   // R4: overflow flag follows a write at full
   p_ovfl_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && level == FULL_LVL) |=> stat[EV_OVFL]);
   // R6: request implies level reached the threshold
   p_req_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> level != '0);
endmodule

// File: tb/cap_fifo_dma_tb_top.sv
`timescale 1ns/1ps
module cap_fifo_dma_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [6:0]  thr_code = 7'd3;
   logic        dma_en = 1'b0;
   logic [4:0]  irq_en = '0;
   logic [4:0]  stat_clr = '0;
   logic [4:0]  stat;
   logic        dma_req, irq;
   logic [6:0]  wr_ptr, rd_ptr;
   logic [7:0]  level, peak;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cap_fifo_dma dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .thr_code(thr_code), .dma_en(dma_en),
      .irq_en(irq_en), .stat_clr(stat_clr), .stat(stat), .dma_req(dma_req),
      .irq(irq), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .peak(peak));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic w, input logic [31:0] d, input logic r, input logic [4:0] c);
      wr_en = w; wr_data = d; rd_en = r; stat_clr = c;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0; stat_clr = '0;
   endtask

   task automatic sweep_thr(input int lvl);
      dma_en = 1'b1;
      for (int t = 0; t < 128; t++) begin
         thr_code = 7'(t);
         #0.001;
         check("R6 dma_req", 32'(dma_req), 32'(lvl >= t + 1));
      end
      dma_en = 1'b0;
      for (int t = 0; t < 128; t += 37) begin
         thr_code = 7'(t);
         #0.001;
         check("R7 dma_req off", 32'(dma_req), 32'd0);
      end
      thr_code = 7'd3;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 level", 32'(level), 0);
      check("R1 peak", 32'(peak), 0);
      check("R1 wr_ptr", 32'(wr_ptr), 0);
      check("R1 rd_ptr", 32'(rd_ptr), 0);
      check("R1 stat", 32'(stat), 0);
      check("R1 rd_data", rd_data, 0);
      check("R1 dma_req", 32'(dma_req), 0);
      check("R1 irq", 32'(irq), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R5 underflow on empty
      cyc(0, 0, 1, 0);
      check("R5 rd_data", rd_data, 0);
      check("R5 level", 32'(level), 0);
      check("R5 rd_ptr", 32'(rd_ptr), 0);
      check("R5 stat underflow", 32'(stat[4]), 1);
      cyc(0, 0, 0, 5'h1F);
      check("R10 clear all", 32'(stat), 0);

      // fill and exhaustive threshold sweep
      sweep_thr(0);
      for (int i = 0; i < 128; i++) begin
         cyc(1, 32'hA500_0000 + 32'(i), 0, 0);
         check("R3 level up", 32'(level), 32'(i + 1));
         check("R3 wr_ptr", 32'(wr_ptr), 32'((i + 1) % 128));
         check("R8 peak rise", 32'(peak), 32'(i + 1));
         sweep_thr(i + 1);
      end
      // R4 overflow
      cyc(1, 32'hDEAD_BEEF, 0, 0);
      check("R4 level held", 32'(level), 128);
      check("R4 wr_ptr held", 32'(wr_ptr), 0);
      check("R4 and R9 stat", 32'(stat), 32'b01111);

      // drain
      for (int i = 0; i < 128; i++) begin
         cyc(0, 0, 1, 0);
         check("R2 order", rd_data, 32'hA500_0000 + 32'(i));
         check("R3 level down", 32'(level), 32'(127 - i));
         check("R3 rd_ptr", 32'(rd_ptr), 32'((i + 1) % 128));
         check("R8 peak kept", 32'(peak), 128);
      end
      cyc(0, 0, 1, 0);
      check("R5 data kept", rd_data, 32'hA500_007F);
      check("R5 level", 32'(level), 0);
      check("R5 stat", 32'(stat), 32'b11111);

      // R10 selective clear
      cyc(0, 0, 0, 5'b01000);
      check("R10 one bit", 32'(stat), 32'b10111);
      cyc(0, 0, 0, 5'b10111);
      check("R10 rest", 32'(stat), 0);
      irq_en = 5'h1F; #0.001;
      check("R11 none set", 32'(irq), 0);
      irq_en = '0;

      // R9 one-cycle lag of level flags
      cyc(1, 32'h1111_0001, 0, 0);
      check("R9 not yet", 32'(stat[0]), 0);
      cyc(0, 0, 0, 0);
      check("R9 set", 32'(stat[0]), 1);
      cyc(0, 0, 0, 5'b00001);
      check("R10 set wins", 32'(stat[0]), 1);

      // R11 masking
      irq_en = 5'b00010; #0.001;
      check("R11 masked", 32'(irq), 0);
      irq_en = 5'b00001; #0.001;
      check("R11 enabled", 32'(irq), 1);
      irq_en = 5'b00000; #0.001;
      check("R11 all off", 32'(irq), 0);

      // R3 simultaneous access, R2 order
      cyc(1, 32'h1111_0002, 0, 0);
      cyc(1, 32'h1111_0003, 1, 0);
      check("R3 level both", 32'(level), 2);
      check("R2 first", rd_data, 32'h1111_0001);
      cyc(0, 0, 1, 0);
      check("R2 second", rd_data, 32'h1111_0002);
      cyc(0, 0, 1, 0);
      check("R2 third", rd_data, 32'h1111_0003);
      check("R8 peak after clear", 32'(peak), 128);

      // R1 reset again clears peak
      rst_n = 1'b0; #1;
      check("R1 peak reset", 32'(peak), 0);
      check("R1 stat reset", 32'(stat), 0);
      check("R1 level reset", 32'(level), 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule